// File: doc/BRIEF.md
# Serial Port Wake-Up Interrupt and Flag Controller

This block holds the interrupt enables, the status flags and the interrupt request logic of an asynchronous serial port that can share one line among several stations. A receiver core hands it a pulse for every completed frame, along with the frame's address-marker bit and its framing-error and overrun indications. A transmitter core hands it a pulse when the shift register takes a byte and a strobe at the moment the last data bit would start. From these events and the software-written enables, the block keeps five status flags and drives four registered level interrupt requests. It also decides whether the serial clock pin is driven.

In wake-up mode the receiving station ignores traffic that is not addressed to it. Software sets the wake enable and waits. Every frame whose marker bit is 0 is dropped without a trace. The first frame whose marker bit is 1 is taken in like a normal frame, and the same frame clears the wake enable in hardware, so that the traffic that follows is received normally. The wake enable has an effect only in asynchronous mode with the marker protocol switched on.

Software clears a flag by reading the status word and then writing 0 to that bit. A write of 0 that has no read of 1 before it is refused. This stops software from clearing a flag that hardware raised after the read.

Top module: `sci_wake_irq`

## Requirements
- R1: After a synchronous reset all enables, the wake enable, the mode bits, every interrupt output and `sck_oe` are 0, and `status_o` is 5'b00011 (the transmit-empty and transmit-end flags are set).
- R2: When wake-up is not in effect, a `rx_done` pulse sets the framing flag (status bit 3) if `rx_ferr` is high and the overrun flag (status bit 4) if `rx_ovr` is high. It sets the receive-full flag (status bit 2) only when neither error is present.
- R3: Wake-up is in effect when the wake enable (control bit 3) is 1, the marker enable (mode bit 1) is 1 and the sync select (mode bit 0) is 0. While it is in effect, a frame with `rx_mpb`=0 sets no flag and raises no request.
- R4: While wake-up is in effect, a frame with `rx_mpb`=1 clears the wake enable, and that frame is accepted exactly as in R2.
- R5: With the sync select set to 1, or with the marker enable at 0, the wake enable is ignored. Frames are accepted as in R2, and the wake enable keeps its value.
- R6: The requests follow the flags one clock later. `rxi` = receive-full AND receive enable (control bit 0). `eri` = (framing OR overrun) AND receive enable. `txi` = transmit-empty (status bit 0) AND transmit enable (control bit 1).
- R7: `tx_take` sets the transmit-empty flag. `tx_msb_strobe` sets the transmit-end flag (status bit 1) only when `tx_data_valid` is 0.
- R8: `tei` = transmit-end AND transmit-end enable (control bit 2), registered. It falls when that enable is written to 0 or when transmit-end is cleared.
- R9: A status write (`reg_sel`=2) clears a flag whose data bit is 0, but only if a `stat_rd_en` pulse saw that flag at 1 after it was last set. A write without that read, and any data bit at 1, leave the flag unchanged.
- R10: `sck_oe` follows the clock select (control bits 5:4) one clock after the register changes. In asynchronous mode it is 1 only for select 01. In sync mode it is 1 when select bit 5 is 0, whatever bit 4 holds.
- R11: A hardware set wins over a software clear in the same cycle. The set also cancels any earlier read, so a later write of 0 needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 mode, 2 status |
| reg_wdata | input | DATA_W | Write data |
| stat_rd_en | input | 1 | Status read strobe; arms the flags that are 1 for clearing |
| rx_done | input | 1 | Receive frame completed pulse |
| rx_mpb | input | 1 | Address-marker bit of the completed frame |
| rx_ferr | input | 1 | Framing error of the completed frame |
| rx_ovr | input | 1 | Overrun on the completed frame |
| tx_take | input | 1 | Transmit shifter took the data byte |
| tx_msb_strobe | input | 1 | Time at which the last data bit would be sent |
| tx_data_valid | input | 1 | Transmit data register holds valid data |
| rxi | output | 1 | Receive-full interrupt request |
| eri | output | 1 | Receive-error interrupt request |
| txi | output | 1 | Transmit-empty interrupt request |
| tei | output | 1 | Transmit-end interrupt request |
| sck_oe | output | 1 | Serial clock pin output enable |
| status_o | output | 5 | Flags: bit0 tx empty, bit1 tx end, bit2 rx full, bit3 framing, bit4 overrun |
| wake_o | output | 1 | Current wake enable |

## Verification
The assertions watch every cycle for the following. Dropped frames must leave the flag set lines quiet. A marker frame under wake-up must clear the wake enable. A set must always land in the flag, and a clear must never land without an armed read. Each request may only be high when its flag and its enable were high the cycle before. What the assertions cannot show is the whole sequence: a run of dropped frames, then the wake frame, then normal traffic, and the read-then-write clear protocol as software sees it. The bench's scenarios cover these, along with the full table of clock-select and mode settings for the pin direction.

// File: rtl/sci_wake_pkg.sv
package sci_wake_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  localparam int NFLAG  = 5;
  localparam int F_TDRE = 0;
  localparam int F_TEND = 1;
  localparam int F_RDRF = 2;
  localparam int F_FER  = 3;
  localparam int F_ORER = 4;

  // control word: [5:4] clock select, [3] wake, [2] tx-end ie, [1] tx ie, [0] rx ie
  typedef struct packed {
    logic [1:0] clk_sel;
    logic       wake_en;
    logic       tend_ie;
    logic       tx_ie;
    logic       rx_ie;
  } ctrl_t;

  // mode word: [1] marker protocol, [0] synchronous
  typedef struct packed {
    logic mp_mode;
    logic sync_mode;
  } mode_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/sci_cfg_regs.sv
module sci_cfg_regs
  import sci_wake_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake_clr,
  output ctrl_t             ctrl_q,
  output mode_t             mode_q,
  output logic              sck_oe
);
  logic sck_next;

  always_comb begin
    if (mode_q.sync_mode) sck_next = ~ctrl_q.clk_sel[1];
    else                  sck_next = ~ctrl_q.clk_sel[1] & ctrl_q.clk_sel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
      sck_oe <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (wake_clr)               ctrl_q.wake_en <= 1'b0;
      if (wr_en && wr_sel == SEL_MODE) mode_q <= mode_t'(wdata[MODE_W-1:0]);
      sck_oe <= sck_next;
    end
  end

  // R10: an external clock select never leaves the pin driven
  p_sck_ext_r10: assert property (@(posedge clk) disable iff (rst)
    sck_oe |-> !$past(ctrl_q.clk_sel[1]));
endmodule

// File: rtl/sci_rx_gate.sv
module sci_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic rx_done,
  input  logic rx_mpb,
  input  logic rx_ferr,
  input  logic rx_ovr,
  input  logic wake_en,
  input  logic mp_mode,
  input  logic sync_mode,
  output logic set_rdrf,
  output logic set_fer,
  output logic set_orer,
  output logic wake_clr
);
  logic wake_live;
  logic accept;

  assign wake_live = wake_en & mp_mode & ~sync_mode;
  assign accept    = rx_done & (~wake_live | rx_mpb);
  assign wake_clr  = rx_done & wake_live & rx_mpb;
  assign set_fer   = accept & rx_ferr;
  assign set_orer  = accept & rx_ovr;
  assign set_rdrf  = accept & ~rx_ferr & ~rx_ovr;

  // R3: a dropped frame touches no flag
  p_discard_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_done && wake_en && mp_mode && !sync_mode && !rx_mpb)
      |-> !(set_rdrf || set_fer || set_orer));

  // R5: no wake clear outside asynchronous marker mode
  p_wake_scope_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_mode || !mp_mode) |-> !wake_clr);

  // R2: exactly one outcome class per accepted frame
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    set_rdrf |-> !(set_fer || set_orer));
endmodule

// File: rtl/sci_flag_bit.sv
module sci_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd,
  input  logic wr_clr,
  output logic q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RST_VAL;
      armed <= 1'b0;
    end else if (set) begin
      q     <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (wr_clr && armed) begin
        q     <= 1'b0;
        armed <= 1'b0;
      end else if (rd && q) begin
        armed <= 1'b1;
      end
    end
  end

  // R11: hardware set always lands
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    set |=> q);

  // R9: a clear without a prior read of 1 is refused
  p_clr_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    (q && !set && wr_clr && !armed) |=> q);
endmodule

// File: rtl/sci_wake_irq.sv
module sci_wake_irq
  import sci_wake_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              stat_rd_en,
  input  logic              rx_done,
  input  logic              rx_mpb,
  input  logic              rx_ferr,
  input  logic              rx_ovr,
  input  logic              tx_take,
  input  logic              tx_msb_strobe,
  input  logic              tx_data_valid,
  output logic              rxi,
  output logic              eri,
  output logic              txi,
  output logic              tei,
  output logic              sck_oe,
  output logic [NFLAG-1:0]  status_o,
  output logic              wake_o
);
  localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'((1 << F_TDRE) | (1 << F_TEND));

  ctrl_t            ctrl_q;
  mode_t            mode_q;
  logic             wake_clr;
  logic             set_rdrf, set_fer, set_orer;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flag_q;
  logic             stat_wr;

  sci_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_sel),
    .wdata(reg_wdata), .wake_clr(wake_clr),
    .ctrl_q(ctrl_q), .mode_q(mode_q), .sck_oe(sck_oe)
  );

  sci_rx_gate u_gate (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_mpb(rx_mpb),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .wake_en(ctrl_q.wake_en),
    .mp_mode(mode_q.mp_mode), .sync_mode(mode_q.sync_mode),
    .set_rdrf(set_rdrf), .set_fer(set_fer), .set_orer(set_orer),
    .wake_clr(wake_clr)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[F_TDRE] = tx_take;
    set_vec[F_TEND] = tx_msb_strobe & ~tx_data_valid;
    set_vec[F_RDRF] = set_rdrf;
    set_vec[F_FER]  = set_fer;
    set_vec[F_ORER] = set_orer;
  end

  assign stat_wr = reg_wr_en && (reg_sel == SEL_STAT);
  assign clr_vec = {NFLAG{stat_wr}} & ~reg_wdata[NFLAG-1:0];

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sci_flag_bit #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk(clk), .rst(rst), .set(set_vec[i]), .rd(stat_rd_en),
      .wr_clr(clr_vec[i]), .q(flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxi <= 1'b0;
      eri <= 1'b0;
      txi <= 1'b0;
      tei <= 1'b0;
    end else begin
      rxi <= flag_q[F_RDRF] & ctrl_q.rx_ie;
      eri <= (flag_q[F_FER] | flag_q[F_ORER]) & ctrl_q.rx_ie;
      txi <= flag_q[F_TDRE] & ctrl_q.tx_ie;
      tei <= flag_q[F_TEND] & ctrl_q.tend_ie;
    end
  end

  assign status_o = flag_q;
  assign wake_o   = ctrl_q.wake_en;

  // R4: marker frame under wake-up drops the wake enable
  p_wake_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_mpb && wake_o && mode_q.mp_mode && !mode_q.sync_mode
     && !(reg_wr_en && reg_sel == SEL_CTRL)) |=> !wake_o);

  // R8: transmit-end request only with flag and enable one cycle before
  p_tei_src_r8: assert property (@(posedge clk) disable iff (rst)
    tei |-> $past(status_o[F_TEND] && ctrl_q.tend_ie));

  // R6: receive requests need the receive enable
  p_rx_req_en_r6: assert property (@(posedge clk) disable iff (rst)
    (rxi || eri) |-> $past(ctrl_q.rx_ie));
endmodule

// File: tb/tb_sci_wake_irq.sv
module tb_sci_wake_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       stat_rd_en = 1'b0;
  logic       rx_done = 1'b0, rx_mpb = 1'b0, rx_ferr = 1'b0, rx_ovr = 1'b0;
  logic       tx_take = 1'b0, tx_msb_strobe = 1'b0, tx_data_valid = 1'b0;
  logic       rxi, eri, txi, tei, sck_oe, wake_o;
  logic [4:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sci_wake_irq dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .stat_rd_en(stat_rd_en), .rx_done(rx_done),
    .rx_mpb(rx_mpb), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .tx_take(tx_take),
    .tx_msb_strobe(tx_msb_strobe), .tx_data_valid(tx_data_valid),
    .rxi(rxi), .eri(eri), .txi(txi), .tei(tei), .sck_oe(sck_oe),
    .status_o(status_o), .wake_o(wake_o)
  );

  // {sync, clk_sel[1:0], expected sck_oe}
  localparam logic [3:0] SCK_TBL [8] = '{
    4'b0_00_0, 4'b0_01_1, 4'b0_10_0, 4'b0_11_0,
    4'b1_00_1, 4'b1_01_1, 4'b1_10_0, 4'b1_11_0
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd_en = 1'b1;
    @(negedge clk); stat_rd_en = 1'b0;
  endtask

  task automatic frame(input logic m, input logic fe, input logic ov);
    @(negedge clk); rx_done = 1'b1; rx_mpb = m; rx_ferr = fe; rx_ovr = ov;
    @(negedge clk); rx_done = 1'b0; rx_mpb = 1'b0; rx_ferr = 1'b0; rx_ovr = 1'b0;
  endtask

  task automatic msb(input logic valid);
    @(negedge clk); tx_msb_strobe = 1'b1; tx_data_valid = valid;
    @(negedge clk); tx_msb_strobe = 1'b0; tx_data_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  task automatic clear_all();
    rd();
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(status_o, 8'h03, "R1 status");
    chk({rxi, eri, txi, tei}, 4'h0, "R1 requests");
    chk(sck_oe, 1'b0, "R1 sck_oe");
    chk(wake_o, 1'b0, "R1 wake");

    // R10 clock pin table
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {7'd0, SCK_TBL[i][3]});
      wr(2'd0, {2'b00, SCK_TBL[i][2:1], 4'h0});
      @(negedge clk);
      chk(sck_oe, SCK_TBL[i][0], $sformatf("R10 sck row %0d", i));
    end

    // R3 dropped frames under wake-up
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h09);
    frame(1'b0, 1'b1, 1'b1);
    chk(status_o, 8'h03, "R3 no flags on marker 0");
    chk(wake_o, 1'b1, "R3 wake held");
    @(negedge clk);
    chk({rxi, eri}, 2'b00, "R3 no requests");

    // R4 marker frame wakes and is accepted
    frame(1'b1, 1'b0, 1'b0);
    chk(wake_o, 1'b0, "R4 wake cleared");
    chk(status_o, 8'h07, "R4 frame accepted");
    @(negedge clk);
    chk(rxi, 1'b1, "R6 rxi follows rx full");

    // R9 clear protocol
    wr(2'd2, 8'h00);
    chk(status_o, 8'h07, "R9 write without read");
    rd();
    wr(2'd2, 8'h1F);
    chk(status_o, 8'h07, "R9 write of ones");
    wr(2'd2, 8'h00);
    chk(status_o, 8'h00, "R9 read then write 0");
    @(negedge clk);
    chk(rxi, 1'b0, "R6 rxi drops");

    // R2 normal reception with errors
    frame(1'b0, 1'b1, 1'b0);
    chk(status_o, 8'h08, "R2 framing error");
    @(negedge clk);
    chk(eri, 1'b1, "R6 eri");
    frame(1'b0, 1'b0, 1'b1);
    chk(status_o, 8'h18, "R2 overrun no rx full");
    clear_all();

    // R5 wake ignored in sync mode and without marker mode
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h09);
    frame(1'b0, 1'b0, 1'b0);
    chk(status_o, 8'h04, "R5 sync accepts");
    chk(wake_o, 1'b1, "R5 wake kept sync");
    clear_all();
    wr(2'd1, 8'h00);
    frame(1'b0, 1'b0, 1'b0);
    chk(status_o, 8'h04, "R5 mp off accepts");
    chk(wake_o, 1'b1, "R5 wake kept mp off");
    clear_all();
    wr(2'd0, 8'h00);

    // R7 / R8 transmit end
    wr(2'd0, 8'h04);
    msb(1'b1);
    chk(status_o, 8'h00, "R7 no tend with valid data");
    @(negedge clk);
    chk(tei, 1'b0, "R8 tei idle");
    msb(1'b0);
    chk(status_o, 8'h02, "R7 tend set");
    @(negedge clk);
    chk(tei, 1'b1, "R8 tei raised");
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk(tei, 1'b0, "R8 tei off by enable");
    wr(2'd0, 8'h04);
    @(negedge clk);
    chk(tei, 1'b1, "R8 tei back");
    clear_all();
    @(negedge clk);
    chk(tei, 1'b0, "R8 tei off by clear");
    take();
    chk(status_o, 8'h01, "R7 tdre set");
    wr(2'd0, 8'h02);
    @(negedge clk);
    chk(txi, 1'b1, "R6 txi");
    wr(2'd0, 8'h00);

    // R11 set beats clear, set disarms
    rd();
    @(negedge clk);
    tx_take = 1'b1; reg_wr_en = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h00;
    @(negedge clk);
    tx_take = 1'b0; reg_wr_en = 1'b0;
    chk(status_o, 8'h01, "R11 set wins");
    wr(2'd2, 8'h00);
    chk(status_o, 8'h01, "R11 set disarms");
    clear_all();
    chk(status_o, 8'h00, "R11 fresh read clears");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule